// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies data by walking a chain of descriptors kept in memory. Each descriptor is a 16-byte record. The channel reads the record, moves the requested number of bytes from a source to a destination in bursts, raises a one-cycle completion pulse and then loads the record named by the descriptor's link word. A ring of descriptors whose last link points back to the first gives endless cyclic buffering, such as an audio ring. Software can compute its position in the buffer from the live source and destination addresses, which the channel exposes at all times.

All memory traffic goes through one master port. The request side is valid/ready: once the channel raises `mem_req_valid`, it holds the address, the write flag and the write data unchanged until `mem_req_ready` is sampled high. Read data comes back on `mem_rsp_valid`/`mem_rsp_data`. The channel accepts data only while `mem_rsp_ready` is high, which is while it waits for a read. Only one read is outstanding at a time.

Control pins are plain levels. `en` gates the start of every new request, so dropping it pauses the channel and raising it resumes the channel. Holding `abort` high with `en` low returns the channel to idle.

Top module: `dma_chain_chan`

## Requirements
- R1: While reset is applied and after it is released, `active`, `desc_loading`, `done_pulse` and `mem_req_valid` are low.
- R2: A `fetch` pulse in idle latches `desc_ptr` and reads four words at ptr, ptr+4, ptr+8 and ptr+12, in that order. The words are taken as byte count, source address, destination address and link address. `desc_loading` is high from the cycle after `fetch` until the fourth word has been captured, and it rises again for every descriptor loaded automatically.
- R3: The burst length in bytes is 4 shifted left by `burst_sel` (`burst_sel` 0..5 gives 4, 8, 16, 32, 64 or 128 bytes; values 6 and 7 act as 5). Each burst reads all of its words before it writes any of them. The last burst of a descriptor is shortened to the bytes that remain.
- R4: With `src_hold`=0 the source address advances by 4 after each data read, and with `src_hold`=1 it stays fixed. `dst_hold` sets the destination address in the same way for writes.
- R5: When a descriptor's byte count runs out, `done_pulse` is high for exactly one cycle. The channel then loads the descriptor at the link address, so a link back to the first descriptor repeats the ring without end.
- R6: A descriptor with a byte count of zero gives a completion pulse and moves on to its link without any data read or write.
- R7: While `en` is low the channel starts no new request, and `cur_src`/`cur_dst` hold their values. When `en` returns, the transfer continues with no word lost or repeated.
- R8: `abort` high with `en` low makes `active` and `desc_loading` low on the next cycle. The channel then issues no request until a new `fetch`.
- R9: `cur_src` and `cur_dst` show the address of the next source read and the next destination write. They are loaded from the descriptor and move with every data access.
- R10: `active` rises with the first descriptor load and stays high until an abort.
- R11: A request that is not accepted keeps `mem_req_valid`, address, write flag and write data stable until `mem_req_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low pauses new requests |
| abort | input | 1 | With en low, stops the channel outright |
| fetch | input | 1 | Start pulse: load the descriptor at desc_ptr |
| desc_ptr | input | 32 | Address of the first descriptor (16-byte aligned) |
| burst_sel | input | 3 | Burst length code, bytes = 4 << burst_sel |
| src_hold | input | 1 | 1 keeps the source address fixed |
| dst_hold | input | 1 | 1 keeps the destination address fixed |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Channel is waiting for read data |
| mem_rsp_data | input | 32 | Read data |
| done_pulse | output | 1 | One-cycle descriptor completion |
| active | output | 1 | Channel running or paused |
| desc_loading | output | 1 | Descriptor words being read |
| cur_src | output | 32 | Live source address |
| cur_dst | output | 32 | Live destination address |

## Verification
The checker takes several things for granted about the inputs. Byte counts are multiples of four and no larger than 64 KiB. Descriptors sit on 16-byte boundaries. The memory returns exactly one response for each accepted read, never before the request and never while the channel is not waiting. `abort` is used only with `en` low. The bench memory model keeps to these rules by replying to each accepted read exactly one cycle later, and the descriptor-building tasks only write word-multiple counts at aligned addresses. Every abort is driven with `en` already low.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_CHECK,
    ST_RREQ,
    ST_RWAIT,
    ST_WREQ
  } dma_state_e;

  localparam int unsigned SEL_MAX = 5;
endpackage

// File: rtl/dma_burst_calc.sv
module dma_burst_calc #(
  parameter int CNT_W     = 17,
  parameter int MAX_WORDS = 32,
  parameter int WORD_B    = 4,
  parameter int BL_W      = 6
) (
  input  logic [2:0]       burst_sel,
  input  logic [CNT_W-1:0] remain,
  output logic [BL_W-1:0]  words
);
  import dma_chain_pkg::*;
  localparam logic [CNT_W-1:0] CAP   = CNT_W'(MAX_WORDS * WORD_B);
  localparam logic [CNT_W-1:0] WBYTE = CNT_W'(WORD_B);

  logic [2:0]       sel;
  logic [CNT_W-1:0] want;
  logic [CNT_W-1:0] take;

  always_comb begin
    sel  = (burst_sel > 3'(SEL_MAX)) ? 3'(SEL_MAX) : burst_sel;
    want = WBYTE << sel;
    if (want > CAP) want = CAP;
    take  = (remain < want) ? remain : want;
    words = BL_W'(take / WBYTE);
  end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slot_q[wr_idx] <= wr_data;
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          hold,
  output logic [AW-1:0] nxt
);
  assign nxt = hold ? addr : addr + AW'(STEP);
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int AW              = 32,
  parameter int DW              = 32,
  parameter int CNT_W           = 17,
  parameter int MAX_BURST_WORDS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          abort,
  input  logic          fetch,
  input  logic [AW-1:0] desc_ptr,
  input  logic [2:0]    burst_sel,
  input  logic          src_hold,
  input  logic          dst_hold,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done_pulse,
  output logic          active,
  output logic          desc_loading,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst
);
  localparam int WORD_B = DW / 8;
  localparam int IDX_W  = $clog2(MAX_BURST_WORDS);
  localparam int BL_W   = IDX_W + 1;
  localparam logic [CNT_W-1:0] WBYTE = CNT_W'(WORD_B);

  dma_state_e       state_q;
  logic [AW-1:0]    ptr_q, next_q, src_q, dst_q;
  logic [1:0]       widx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BL_W-1:0]  blen_q, bidx_q;
  logic             done_q, active_q, loading_q, hold_q;

  logic [AW-1:0]    src_nxt, dst_nxt;
  logic [BL_W-1:0]  burst_words;
  logic [DW-1:0]    buf_rd;
  logic             in_req, acc, rsp, kill, last_beat, buf_we;

  dma_addr_step #(.AW(AW), .STEP(WORD_B)) u_src_step (
    .addr(src_q), .hold(src_hold), .nxt(src_nxt));
  dma_addr_step #(.AW(AW), .STEP(WORD_B)) u_dst_step (
    .addr(dst_q), .hold(dst_hold), .nxt(dst_nxt));

  dma_burst_calc #(.CNT_W(CNT_W), .MAX_WORDS(MAX_BURST_WORDS),
                   .WORD_B(WORD_B), .BL_W(BL_W)) u_calc (
    .burst_sel(burst_sel), .remain(cnt_q), .words(burst_words));

  dma_burst_buf #(.DEPTH(MAX_BURST_WORDS), .DW(DW), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(buf_we), .wr_idx(bidx_q[IDX_W-1:0]), .wr_data(mem_rsp_data),
    .rd_idx(bidx_q[IDX_W-1:0]), .rd_data(buf_rd));

  always_comb begin
    in_req        = (state_q == ST_DREQ) || (state_q == ST_RREQ) || (state_q == ST_WREQ);
    mem_req_valid = in_req && (en || hold_q);
    mem_req_write = (state_q == ST_WREQ);
    mem_rsp_ready = (state_q == ST_DWAIT) || (state_q == ST_RWAIT);
    case (state_q)
      ST_DREQ: mem_req_addr = ptr_q + AW'({widx_q, 2'b00});
      ST_WREQ: mem_req_addr = dst_q;
      default: mem_req_addr = src_q;
    endcase
    mem_req_wdata = buf_rd;
    acc       = mem_req_valid && mem_req_ready;
    rsp       = mem_rsp_valid && mem_rsp_ready;
    kill      = abort && !en;
    last_beat = (bidx_q == blen_q - BL_W'(1));
    buf_we    = (state_q == ST_RWAIT) && rsp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      next_q    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      widx_q    <= '0;
      cnt_q     <= '0;
      blen_q    <= '0;
      bidx_q    <= '0;
      done_q    <= 1'b0;
      active_q  <= 1'b0;
      loading_q <= 1'b0;
      hold_q    <= 1'b0;
    end else if (kill) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      active_q  <= 1'b0;
      loading_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      hold_q <= mem_req_valid && !mem_req_ready;
      case (state_q)
        ST_IDLE: if (fetch) begin
          ptr_q     <= desc_ptr;
          widx_q    <= '0;
          active_q  <= 1'b1;
          loading_q <= 1'b1;
          state_q   <= ST_DREQ;
        end
        ST_DREQ: if (acc) state_q <= ST_DWAIT;
        ST_DWAIT: if (rsp) begin
          case (widx_q)
            2'd0: cnt_q  <= mem_rsp_data[CNT_W-1:0];
            2'd1: src_q  <= mem_rsp_data;
            2'd2: dst_q  <= mem_rsp_data;
            default: next_q <= mem_rsp_data;
          endcase
          widx_q <= widx_q + 2'd1;
          if (widx_q == 2'd3) begin
            loading_q <= 1'b0;
            state_q   <= ST_CHECK;
          end else begin
            state_q <= ST_DREQ;
          end
        end
        ST_CHECK: if (cnt_q == '0) begin
          done_q    <= 1'b1;
          ptr_q     <= next_q;
          widx_q    <= '0;
          loading_q <= 1'b1;
          state_q   <= ST_DREQ;
        end else begin
          blen_q  <= burst_words;
          bidx_q  <= '0;
          state_q <= ST_RREQ;
        end
        ST_RREQ: if (acc) state_q <= ST_RWAIT;
        ST_RWAIT: if (rsp) begin
          src_q <= src_nxt;
          if (last_beat) begin
            bidx_q  <= '0;
            state_q <= ST_WREQ;
          end else begin
            bidx_q  <= bidx_q + BL_W'(1);
            state_q <= ST_RREQ;
          end
        end
        ST_WREQ: if (acc) begin
          dst_q <= dst_nxt;
          cnt_q <= cnt_q - WBYTE;
          if (!last_beat) begin
            bidx_q <= bidx_q + BL_W'(1);
          end else if (cnt_q == WBYTE) begin
            done_q    <= 1'b1;
            ptr_q     <= next_q;
            widx_q    <= '0;
            loading_q <= 1'b1;
            state_q   <= ST_DREQ;
          end else begin
            state_q <= ST_CHECK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_pulse   = done_q;
  assign active       = active_q;
  assign desc_loading = loading_q;
  assign cur_src      = src_q;
  assign cur_dst      = dst_q;
endmodule

// File: rtl/dma_chain_chan_chk.sv
module dma_chain_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          abort,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_ready,
  input logic          done_pulse,
  input logic          active,
  input logic          desc_loading,
  input logic [AW-1:0] cur_src,
  input logic [AW-1:0] cur_dst
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !(abort && !en) |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
      $stable(mem_req_wdata)); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R5

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !en |=> !active && !desc_loading && !mem_req_valid); // R8

  AST_PAUSE_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> en); // R7

  AST_PAUSE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !(mem_rsp_valid && mem_rsp_ready) && !(mem_req_valid && mem_req_ready) |=>
      $stable(cur_src) && $stable(cur_dst)); // R7

  AST_LOAD_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_loading |-> active); // R10
endmodule

bind dma_chain_chan dma_chain_chan_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .abort(abort),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready), .done_pulse(done_pulse), .active(active),
  .desc_loading(desc_loading), .cur_src(cur_src), .cur_dst(cur_dst));

// File: tb/dma_chain_chan_tb_top.sv
module dma_chain_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, abort = 1'b0, fetch = 1'b0;
  logic [31:0] desc_ptr = '0;
  logic [2:0]  burst_sel = '0;
  logic        src_hold = 1'b0, dst_hold = 1'b0;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_pulse, active, desc_loading;
  logic [31:0] cur_src, cur_dst;

  always #2 clk = ~clk;

  dma_chain_chan dut_i (.*);

  int errors = 0, checks = 0;
  int dones_seen = 0, writes_seen = 0, req_cnt = 0, cyc = 0;
  bit rdy_mode = 1'b0;
  logic [31:0] dmem [logic [31:0]];
  logic [31:0] fifo_val = 32'h100, fifo_exp = 32'h100;
  logic [31:0] exp_addr[$], exp_data[$], dread_log[$];
  string ops = "";
  bit rsp_pend = 1'b0;
  logic [31:0] pend_data = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // memory model and monitor: scoreboard pops expected writes
  initial begin
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (done_pulse) dones_seen++;
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
        rsp_pend      = 1'b0;
      end
      mem_req_ready = rdy_mode ? (cyc % 3 != 2) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        if (mem_req_write) begin
          writes_seen++;
          ops = {ops, "W"};
          if (exp_addr.size() == 0) begin
            chk(1'b0, "R4 unexpected write", mem_req_addr, 32'h0);
          end else begin
            logic [31:0] ea, ed;
            ea = exp_addr.pop_front();
            ed = exp_data.pop_front();
            chk(mem_req_addr == ea, "R4 write address", mem_req_addr, ea);
            chk(mem_req_wdata == ed, "R7 write data", mem_req_wdata, ed);
          end
        end else begin
          if (mem_req_addr < 32'h2000) dread_log.push_back(mem_req_addr);
          else ops = {ops, "R"};
          if (dmem.exists(mem_req_addr)) pend_data = dmem[mem_req_addr];
          else if (mem_req_addr >= 32'hF000_0000) begin
            pend_data = fifo_val;
            fifo_val++;
          end else pend_data = pat(mem_req_addr);
          rsp_pend = 1'b1;
        end
      end
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n);
    dmem[a] = c; dmem[a + 4] = s; dmem[a + 8] = d; dmem[a + 12] = n;
  endtask

  task automatic expect_xfer(input int cnt, input logic [31:0] s, input logic [31:0] d,
                             input bit sh, input bit dh);
    for (int i = 0; i < cnt / 4; i++) begin
      logic [31:0] sa;
      sa = sh ? s : s + 32'(4 * i);
      exp_addr.push_back(dh ? d : d + 32'(4 * i));
      if (sa >= 32'hF000_0000) begin
        exp_data.push_back(fifo_exp);
        fifo_exp++;
      end else exp_data.push_back(pat(sa));
    end
  endtask

  task automatic clear_logs();
    ops = "";
    dread_log.delete();
    dones_seen = 0;
    writes_seen = 0;
  endtask

  task automatic start(input logic [31:0] p);
    @(negedge clk);
    en = 1'b1; desc_ptr = p; fetch = 1'b1;
    @(negedge clk);
    fetch = 1'b0;
  endtask

  task automatic wait_dones(input int n, input string req);
    int t = 0;
    while (dones_seen < n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(dones_seen >= n, req, 32'(dones_seen), 32'(n));
  endtask

  task automatic stop_chan();
    @(negedge clk);
    en = 1'b0; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(!active && !desc_loading && !done_pulse && !mem_req_valid, "R1 in reset",
        {active, desc_loading, done_pulse, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!active && !desc_loading && !done_pulse && !mem_req_valid, "R1 after reset",
        {active, desc_loading, done_pulse, mem_req_valid}, 32'h0);

    // T1: single descriptor ring, 16-byte bursts, back-pressure
    rdy_mode = 1'b1; burst_sel = 3'd2;
    put_desc(32'h1000, 24, 32'h2000, 32'h4000, 32'h1000);
    expect_xfer(24, 32'h2000, 32'h4000, 0, 0);
    clear_logs();
    start(32'h1000);
    chk(desc_loading && active, "R2 loading after fetch", {desc_loading, active}, 32'h3);
    begin
      int t = 0;
      while (desc_loading && t < 200) begin @(negedge clk); t++; end
    end
    chk(dread_log.size() == 4 && dread_log[0] == 32'h1000 && dread_log[1] == 32'h1004 &&
        dread_log[2] == 32'h1008 && dread_log[3] == 32'h100C, "R2 word order",
        32'(dread_log.size()), 32'd4);
    chk(cur_src == 32'h2000 && cur_dst == 32'h4000, "R9 loaded addresses", cur_src, 32'h2000);
    wait_dones(1, "R5 completion");
    chk(ops == "RRRRWWWWRRWW", "R3 burst and short tail", 32'(ops.len()), 32'd12);
    chk(cur_src == 32'h2018 && cur_dst == 32'h4018, "R9 end position", cur_dst, 32'h4018);
    chk(writes_seen == 6, "R5 word count", 32'(writes_seen), 32'd6);
    stop_chan();
    @(negedge clk);
    chk(!active && !desc_loading, "R8 aborted", {active, desc_loading}, 32'h0);

    // T2: two-descriptor cyclic ring, 4-byte bursts
    rdy_mode = 1'b0; burst_sel = 3'd0;
    put_desc(32'h1100, 8, 32'h2100, 32'h4100, 32'h1110);
    put_desc(32'h1110, 4, 32'h2200, 32'h4200, 32'h1100);
    for (int lap = 0; lap < 2; lap++) begin
      expect_xfer(8, 32'h2100, 32'h4100, 0, 0);
      expect_xfer(4, 32'h2200, 32'h4200, 0, 0);
    end
    clear_logs();
    start(32'h1100);
    wait_dones(4, "R5 ring laps");
    stop_chan();
    chk(ops == "RWRWRWRWRWRW", "R3 single-word bursts", 32'(ops.len()), 32'd12);
    chk(dread_log.size() >= 12 && dread_log[8] == 32'h1100, "R5 link back to first",
        dread_log.size() >= 12 ? dread_log[8] : 32'h0, 32'h1100);
    chk(exp_addr.size() == 0, "R5 all ring writes seen", 32'(exp_addr.size()), 32'd0);

    // T3: zero-count descriptor
    put_desc(32'h1200, 0, 32'h2300, 32'h4300, 32'h1210);
    put_desc(32'h1210, 8, 32'h2300, 32'h4300, 32'h1200);
    expect_xfer(8, 32'h2300, 32'h4300, 0, 0);
    clear_logs();
    start(32'h1200);
    wait_dones(1, "R6 zero-count completion");
    chk(ops.len() == 0 && writes_seen == 0, "R6 no data access", 32'(ops.len()), 32'd0);
    wait_dones(2, "R6 continues to link");
    chk(writes_seen == 2, "R6 next descriptor moved", 32'(writes_seen), 32'd2);
    stop_chan();

    // T4: source held at a FIFO address
    burst_sel = 3'd1; src_hold = 1'b1;
    put_desc(32'h1300, 12, 32'hF000_0000, 32'h4400, 32'h1300);
    expect_xfer(12, 32'hF000_0000, 32'h4400, 1, 0);
    clear_logs();
    start(32'h1300);
    wait_dones(1, "R4 src hold completion");
    chk(cur_src == 32'hF000_0000, "R4 source held", cur_src, 32'hF000_0000);
    stop_chan();
    src_hold = 1'b0;

    // T5: destination held, 128-byte burst shortened
    burst_sel = 3'd5; dst_hold = 1'b1;
    put_desc(32'h1400, 8, 32'h2500, 32'h4800, 32'h1400);
    expect_xfer(8, 32'h2500, 32'h4800, 0, 1);
    clear_logs();
    start(32'h1400);
    wait_dones(1, "R4 dst hold completion");
    chk(cur_dst == 32'h4800, "R4 destination held", cur_dst, 32'h4800);
    chk(ops == "RRWW", "R3 long burst cut to count", 32'(ops.len()), 32'd4);
    stop_chan();
    dst_hold = 1'b0;

    // T6: pause and resume
    burst_sel = 3'd3;
    put_desc(32'h1500, 64, 32'h2600, 32'h4A00, 32'h1500);
    expect_xfer(64, 32'h2600, 32'h4A00, 0, 0);
    clear_logs();
    start(32'h1500);
    begin
      int t = 0;
      while (writes_seen < 3 && t < 500) begin @(negedge clk); t++; end
    end
    en = 1'b0;
    repeat (3) @(negedge clk);
    begin
      logic [31:0] s0, d0;
      int r0, w0;
      s0 = cur_src; d0 = cur_dst; r0 = req_cnt; w0 = writes_seen;
      repeat (20) @(negedge clk);
      chk(req_cnt == r0, "R7 no request while paused", 32'(req_cnt), 32'(r0));
      chk(cur_src == s0 && cur_dst == d0, "R7 position held", cur_dst, d0);
      chk(writes_seen == w0, "R7 no writes while paused", 32'(writes_seen), 32'(w0));
    end
    en = 1'b1;
    wait_dones(1, "R7 resumed to completion");
    chk(writes_seen == 16 && exp_addr.size() == 0, "R7 no word lost", 32'(writes_seen), 32'd16);
    stop_chan();

    // T7: abort mid transfer, then idle until new fetch
    burst_sel = 3'd0;
    put_desc(32'h1600, 64, 32'h2700, 32'h4C00, 32'h1600);
    expect_xfer(64, 32'h2700, 32'h4C00, 0, 0);
    clear_logs();
    start(32'h1600);
    begin
      int t = 0;
      while (writes_seen < 2 && t < 500) begin @(negedge clk); t++; end
    end
    stop_chan();
    chk(!active && !desc_loading, "R8 abort mid transfer", {active, desc_loading}, 32'h0);
    exp_addr.delete(); exp_data.delete();
    en = 1'b1;
    repeat (2) @(negedge clk);
    begin
      int r0;
      r0 = req_cnt;
      repeat (20) @(negedge clk);
      chk(req_cnt == r0, "R8 idle after abort", 32'(req_cnt), 32'(r0));
      chk(!active, "R10 active stays low", {31'h0, active}, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule